// File: doc/BRIEF.md
# Shared-Clock Dual-Port RAM with Write-Collision Policy and Flags

This block is a word-addressed memory with two ports, A and B, that share one clock. Each port has an enable, a write enable, an address, write data and a registered read data output. Either port can read or write any word in any cycle.

A parameter picks, for each instance, what a port's read data register shows in a cycle where that same port writes. In read-first mode it shows the word as it was before the write. In write-first mode it shows the data being written. In no-change mode it keeps its previous value.

The block also watches for interactions between the two ports. If one port reads a word in the same cycle that the other port writes it, and the mode is not read-first, the reading port's result is marked stale by a registered flag that travels with the data. If both ports write one word in the same cycle, a registered clash flag is raised. The two ports are applied in a fixed order, so port B's data is the one kept.

Top module: `twin_ram`

## Requirements
- R1: While rst_ni is low, both read data outputs, both stale flags and the clash flag are 0.
- R2: A port that is enabled and not writing presents the stored word at its address on its read data output after the next rising clock edge.
- R3: With WMODE = 0 (read-first), a port that writes shows the word's previous contents on its read data output after that edge.
- R4: With WMODE = 1 (write-first), a port that writes shows its own write data on its read data output after that edge.
- R5: With WMODE = 2 (no-change), a port that writes leaves its read data output unchanged.
- R6: A port whose enable is low does not write the memory, and its read data output and stale flag keep their values, whatever its write enable, address and data are.
- R7: With WMODE = 0, a port reading a word that the other port writes in the same cycle returns the old contents, and its stale flag is 0.
- R8: With WMODE = 1 or 2, a port that is enabled, not writing, and reads the word that the other port writes in the same cycle raises its stale flag after that edge. The flag goes back to 0 after the next edge where that port is enabled and this condition does not hold.
- R9: When both ports write the same address in one cycle, wr_clash_o is 1 after that edge and 0 after any edge where this is not the case. Port B's data is the one stored.
- R10: Two writes to different addresses in the same cycle both take effect, and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both ports |
| rst_ni | input | 1 | Active-low asynchronous reset for the output and flag registers |
| a_en_i | input | 1 | Port A enable |
| a_we_i | input | 1 | Port A write enable |
| a_addr_i | input | ADDR_W | Port A word address |
| a_wdata_i | input | DATA_W | Port A write data |
| a_rdata_o | output | DATA_W | Port A registered read data |
| a_stale_o | output | 1 | Port A read data invalidated by a port B write to the same word |
| b_en_i | input | 1 | Port B enable |
| b_we_i | input | 1 | Port B write enable |
| b_addr_i | input | ADDR_W | Port B word address |
| b_wdata_i | input | DATA_W | Port B write data |
| b_rdata_o | output | DATA_W | Port B registered read data |
| b_stale_o | output | 1 | Port B read data invalidated by a port A write to the same word |
| wr_clash_o | output | 1 | Both ports wrote one address in the previous cycle |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it. This covers the read data, the stale flags and the clash flag, and no path is longer. The bench changes inputs on the falling edge and reads all outputs 1 ns after the following rising edge. A cycle-level model predicts each output for all three modes at once, and the read data is compared only when the model's stale flag for that port is clear. A word the bench has never written counts as unknown, so it is never compared.

// File: rtl/twin_ram_pkg.sv
package twin_ram_pkg;
  typedef enum logic [1:0] {
    WM_READ_FIRST  = 2'd0,
    WM_WRITE_FIRST = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wmode_e;
endpackage

// File: rtl/twin_ram_array.sv
module twin_ram_array #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 11,
  parameter int NPORT  = 2
) (
  input  logic                           clk_i,
  input  logic [NPORT-1:0]               wr_v_i,
  input  logic [NPORT-1:0][ADDR_W-1:0]   addr_v_i,
  input  logic [NPORT-1:0][DATA_W-1:0]   wdata_v_i,
  output logic [NPORT-1:0][DATA_W-1:0]   raw_v_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // later ports override earlier ones on the same word
  always_ff @(posedge clk_i) begin
    for (int p = 0; p < NPORT; p++) begin
      if (wr_v_i[p]) mem_q[addr_v_i[p]] <= wdata_v_i[p];
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    assign raw_v_o[p] = mem_q[addr_v_i[p]];
  end
endmodule

// File: rtl/twin_ram_port.sv
module twin_ram_port
  import twin_ram_pkg::*;
#(
  parameter int     DATA_W = 8,
  parameter wmode_e WMODE  = WM_READ_FIRST
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] raw_i,
  output logic [DATA_W-1:0] dout_o
);
  logic              upd;
  logic [DATA_W-1:0] nxt;
  logic [DATA_W-1:0] dout_q;
  logic              past_ok_q;

  always_comb begin
    upd = en_i;
    nxt = raw_i;
    case (WMODE)
      WM_WRITE_FIRST: if (we_i) nxt = wdata_i;
      WM_NO_CHANGE:   if (we_i) upd = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  dout_q <= '0;
    else if (upd) dout_q <= nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  assign dout_o = dout_q;

  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && !$past(en_i) |-> $stable(dout_o));

  if (WMODE == WM_WRITE_FIRST) begin : g_wf_chk
    assert_wf_own_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok_q && $past(en_i && we_i) |-> dout_o == $past(wdata_i));
  end
  if (WMODE == WM_NO_CHANGE) begin : g_nc_chk
    assert_nc_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok_q && $past(en_i && we_i) |-> $stable(dout_o));
  end
endmodule

// File: rtl/twin_ram_collide.sv
module twin_ram_collide
  import twin_ram_pkg::*;
#(
  parameter int     ADDR_W = 11,
  parameter wmode_e WMODE  = WM_READ_FIRST
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_en_i,
  input  logic              a_we_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic              b_en_i,
  input  logic              b_we_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  output logic              a_stale_o,
  output logic              b_stale_o,
  output logic              clash_o
);
  localparam bit CROSS_BAD = (WMODE != WM_READ_FIRST);

  logic same, a_wr, b_wr, a_cross, b_cross;
  logic a_stale_q, b_stale_q, clash_q, past_ok_q;

  assign same    = (a_addr_i == b_addr_i);
  assign a_wr    = a_en_i && a_we_i;
  assign b_wr    = b_en_i && b_we_i;
  assign a_cross = CROSS_BAD && a_en_i && !a_we_i && b_wr && same;
  assign b_cross = CROSS_BAD && b_en_i && !b_we_i && a_wr && same;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_stale_q <= 1'b0;
      b_stale_q <= 1'b0;
      clash_q   <= 1'b0;
      past_ok_q <= 1'b0;
    end else begin
      if (a_en_i) a_stale_q <= a_cross;
      if (b_en_i) b_stale_q <= b_cross;
      clash_q   <= a_wr && b_wr && same;
      past_ok_q <= 1'b1;
    end
  end

  assign a_stale_o = a_stale_q;
  assign b_stale_o = b_stale_q;
  assign clash_o   = clash_q;

  assert_clash_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past(a_en_i && a_we_i && b_en_i && b_we_i && a_addr_i == b_addr_i)
    |-> clash_o);
  assert_stale_a_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $rose(a_stale_o) |-> $past(b_en_i && b_we_i && !a_we_i));
  assert_stale_b_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $rose(b_stale_o) |-> $past(a_en_i && a_we_i && !b_we_i));
  assert_stale_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && !$past(a_en_i) |-> $stable(a_stale_o));

  if (WMODE == WM_READ_FIRST) begin : g_rf_chk
    assert_rf_never_stale_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !a_stale_o && !b_stale_o);
  end
endmodule

// File: rtl/twin_ram.sv
module twin_ram
  import twin_ram_pkg::*;
#(
  parameter int     DATA_W = 8,
  parameter int     ADDR_W = 11,
  parameter wmode_e WMODE  = WM_READ_FIRST
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_en_i,
  input  logic              a_we_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  output logic              a_stale_o,
  input  logic              b_en_i,
  input  logic              b_we_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_rdata_o,
  output logic              b_stale_o,
  output logic              wr_clash_o
);
  localparam int NPORT = 2;

  logic [NPORT-1:0]             en_v, we_v, wr_v;
  logic [NPORT-1:0][ADDR_W-1:0] addr_v;
  logic [NPORT-1:0][DATA_W-1:0] wdata_v, raw_v, dout_v;

  // index 1 = port B, so B is applied last in the array
  assign en_v    = {b_en_i, a_en_i};
  assign we_v    = {b_we_i, a_we_i};
  assign addr_v  = {b_addr_i, a_addr_i};
  assign wdata_v = {b_wdata_i, a_wdata_i};
  assign wr_v    = en_v & we_v;

  twin_ram_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NPORT(NPORT)) u_array (
    .clk_i     (clk_i),
    .wr_v_i    (wr_v),
    .addr_v_i  (addr_v),
    .wdata_v_i (wdata_v),
    .raw_v_o   (raw_v)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    twin_ram_port #(.DATA_W(DATA_W), .WMODE(WMODE)) u_port (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_v[p]),
      .we_i    (we_v[p]),
      .wdata_i (wdata_v[p]),
      .raw_i   (raw_v[p]),
      .dout_o  (dout_v[p])
    );
  end

  twin_ram_collide #(.ADDR_W(ADDR_W), .WMODE(WMODE)) u_collide (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_en_i    (a_en_i),
    .a_we_i    (a_we_i),
    .a_addr_i  (a_addr_i),
    .b_en_i    (b_en_i),
    .b_we_i    (b_we_i),
    .b_addr_i  (b_addr_i),
    .a_stale_o (a_stale_o),
    .b_stale_o (b_stale_o),
    .clash_o   (wr_clash_o)
  );

  assign a_rdata_o = dout_v[0];
  assign b_rdata_o = dout_v[1];
endmodule

// File: tb/twin_ram_test.sv
`timescale 1ns/1ps
module twin_ram_test;
  import twin_ram_pkg::*;
  localparam int DW = 8;
  localparam int AW = 11;
  localparam int NM = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          a_en = 0, a_we = 0, b_en = 0, b_we = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wd = '0, b_wd = '0;

  logic [DW-1:0] qa [NM];
  logic [DW-1:0] qb [NM];
  logic          sa [NM];
  logic          sb [NM];
  logic          cl [NM];

  for (genvar m = 0; m < NM; m++) begin : g_mode
    twin_ram #(.DATA_W(DW), .ADDR_W(AW), .WMODE(wmode_e'(m))) uut (
      .clk_i(clk), .rst_ni(rst_n),
      .a_en_i(a_en), .a_we_i(a_we), .a_addr_i(a_addr), .a_wdata_i(a_wd),
      .a_rdata_o(qa[m]), .a_stale_o(sa[m]),
      .b_en_i(b_en), .b_we_i(b_we), .b_addr_i(b_addr), .b_wdata_i(b_wd),
      .b_rdata_o(qb[m]), .b_stale_o(sb[m]),
      .wr_clash_o(cl[m])
    );
  end

  int checks = 0, failures = 0;
  bit done = 0;

  logic [DW-1:0] ref_mem [1 << AW];
  logic [DW-1:0] eqa [NM];
  logic [DW-1:0] eqb [NM];
  logic          esa [NM];
  logic          esb [NM];
  logic          ecl;

  task automatic chk(string tag, string what, int m, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s mode%0d %s act=%h exp=%h", tag, m, what, act, exp);
    end
  endtask

  // one cycle: drive on falling edge, predict, sample 1 ns after rising edge
  task automatic step(string tag, logic ea, logic wa, logic [AW-1:0] aa, logic [DW-1:0] da,
                      logic eb, logic wb, logic [AW-1:0] ab, logic [DW-1:0] db);
    @(negedge clk);
    a_en = ea; a_we = wa; a_addr = aa; a_wd = da;
    b_en = eb; b_we = wb; b_addr = ab; b_wd = db;
    for (int m = 0; m < NM; m++) begin
      if (ea) begin
        esa[m] = !wa && eb && wb && (aa == ab) && (m != 0);
        if (m == 0)      eqa[m] = ref_mem[aa];
        else if (m == 1) eqa[m] = wa ? da : ref_mem[aa];
        else if (!wa)    eqa[m] = ref_mem[aa];
      end
      if (eb) begin
        esb[m] = !wb && ea && wa && (aa == ab) && (m != 0);
        if (m == 0)      eqb[m] = ref_mem[ab];
        else if (m == 1) eqb[m] = wb ? db : ref_mem[ab];
        else if (!wb)    eqb[m] = ref_mem[ab];
      end
    end
    ecl = ea && wa && eb && wb && (aa == ab);
    if (ea && wa) ref_mem[aa] = da;
    if (eb && wb) ref_mem[ab] = db;
    @(posedge clk); #1;
    for (int m = 0; m < NM; m++) begin
      if (!esa[m] && !$isunknown(eqa[m])) chk(tag, "a_rdata", m, qa[m], eqa[m]);
      if (!esb[m] && !$isunknown(eqb[m])) chk(tag, "b_rdata", m, qb[m], eqb[m]);
      chk(tag, "a_stale", m, {7'b0, sa[m]}, {7'b0, esa[m]});
      chk(tag, "b_stale", m, {7'b0, sb[m]}, {7'b0, esb[m]});
      chk(tag, "clash", m, {7'b0, cl[m]}, {7'b0, ecl});
    end
  endtask

  task automatic t_reset();
    #1;
    for (int m = 0; m < NM; m++) begin
      chk("R1", "a_rdata", m, qa[m], '0);
      chk("R1", "b_rdata", m, qb[m], '0);
      chk("R1", "flags", m, {5'b0, sa[m], sb[m], cl[m]}, '0);
      eqa[m] = '0; eqb[m] = '0; esa[m] = 0; esb[m] = 0;
    end
    ecl = 0;
  endtask

  task automatic t_basic_rd();
    for (int i = 0; i < 16; i++)
      step("R2", 1, 1, AW'(i), DW'(8'h30 + i * 7), 1, 1, AW'(100 + i), DW'(8'hc1 ^ i));
    for (int i = 0; i < 16; i++)
      step("R2", 1, 0, AW'(100 + i), '0, 1, 0, AW'(15 - i), '0);
    step("R2", 1, 0, AW'((1 << AW) - 1), '0, 1, 1, AW'((1 << AW) - 1), 8'h5a);
    step("R2", 1, 0, AW'((1 << AW) - 1), '0, 0, 0, '0, '0);
  endtask

  task automatic t_own_write();
    step("R3 R4 R5", 1, 1, 11'd200, 8'h11, 0, 0, '0, '0);
    step("R3 R4 R5", 1, 1, 11'd200, 8'h22, 1, 1, 11'd201, 8'h33);
    step("R3 R4 R5", 1, 0, 11'd201, '0, 1, 1, 11'd201, 8'h44);
    step("R3 R4 R5", 1, 0, 11'd200, '0, 1, 0, 11'd201, '0);
  endtask

  task automatic t_idle();
    step("R6", 1, 1, 11'd300, 8'haa, 1, 1, 11'd301, 8'hbb);
    step("R6", 1, 0, 11'd300, '0, 1, 0, 11'd301, '0);
    step("R6", 0, 1, 11'd300, 8'h55, 0, 1, 11'd301, 8'h66);
    step("R6", 0, 1, 11'd0, 8'h77, 0, 0, 11'd5, '0);
    step("R6", 1, 0, 11'd300, '0, 1, 0, 11'd301, '0);
  endtask

  task automatic t_cross();
    step("R7 R8", 1, 1, 11'd400, 8'h01, 1, 1, 11'd401, 8'h02);
    step("R7 R8", 1, 0, 11'd400, '0, 1, 1, 11'd400, 8'hf0);
    step("R8", 0, 0, 11'd400, '0, 0, 0, '0, '0);
    step("R8", 1, 0, 11'd400, '0, 0, 0, '0, '0);
    step("R7 R8", 1, 1, 11'd401, 8'he1, 1, 0, 11'd401, '0);
    step("R8", 1, 0, 11'd401, '0, 1, 0, 11'd400, '0);
  endtask

  task automatic t_clash();
    step("R9", 1, 1, 11'd500, 8'h12, 1, 1, 11'd500, 8'h34);
    step("R9", 1, 0, 11'd500, '0, 1, 0, 11'd500, '0);
    step("R9", 1, 1, 11'd500, 8'h9c, 1, 1, 11'd500, 8'h9d);
    step("R9", 0, 1, 11'd500, 8'h01, 1, 1, 11'd500, 8'h02);
    step("R9", 1, 0, 11'd500, '0, 0, 0, '0, '0);
  endtask

  task automatic t_parallel();
    step("R10", 1, 1, 11'd600, 8'h6a, 1, 1, 11'd601, 8'h6b);
    step("R10", 1, 0, 11'd601, '0, 1, 0, 11'd600, '0);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    t_reset();
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_basic_rd();
    t_own_write();
    t_idle();
    t_cross();
    t_clash();
    t_parallel();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule